// File: doc/BRIEF.md
# One-Hertz Real-Time Second Counter

This block is a 32-bit up-counter that advances once per second. An external 32.768 kHz clock reaches it on a single pin. The block brings that pin into the system clock domain through a two-flop synchroniser and turns each rising edge into a one-cycle strobe. A prescaler divides those strobes by 32768 to give the one-hertz count step. Software controls the block through a small word-wide register port. It can write a start value and a match value, turn counting on or off, mask the interrupt, and clear the status bit by writing a one to it.

A three-state machine decides where each count run starts. After reset the machine sits in `ST_FRESH`. When enable is set from there, the count starts at 1 and the machine moves to `ST_RUN`. Clearing enable moves it from `ST_RUN` to `ST_HALT`, and the count holds its value. Setting enable again moves it from `ST_HALT` back to `ST_RUN`, and the count reloads from the start-value register. Only a reset returns the machine to `ST_FRESH`.

While the machine is in `ST_RUN`, the step that lands the count on the match value sets the raw status bit. Counting goes on after that, and the all-ones count wraps to zero. The interrupt line is the raw status bit gated by the mask bit.

Top module: `rtc_second_counter`

## Requirements
- R1: After reset every register reads zero, and `irq` and `match_flag` are low.
- R2: Setting enable (bit 0 at address 2) for the first time after reset loads the count with 1.
- R3: While running, each DIV rising edges on `slow_clk` add exactly one to the count. Fewer edges leave it unchanged.
- R4: Clearing enable stops the count. Later edges on `slow_clk` leave the count value unchanged.
- R5: Setting enable again after a stop loads the count from the start-value register (address 0), not from 1.
- R6: When a step makes the count equal to the match register (address 1), raw status (bit 0 at address 4) becomes 1, and later steps keep counting.
- R7: A step from 0xFFFFFFFF gives a count of 0 and then keeps counting up.
- R8: Masked status (bit 0 at address 5) and `irq` equal raw status AND mask (bit 0 at address 3). `match_flag` equals raw status.
- R9: Writing 1 to bit 0 at address 6 clears raw status, and writing 0 there leaves it unchanged. If a clear and a match step fall in the same cycle, raw status ends up set.
- R10: Addresses 7 and 8 always return the same live count. Writes to addresses 4, 5, 7 and 8 change nothing.
- R11: Each start clears the prescaler, so edges collected before a stop do not count toward the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| slow_clk | input | 1 | 32.768 kHz input, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| match_flag | output | 1 | Raw match status |
| irq | output | 1 | Interrupt, raw status gated by mask |

## Verification
The hardest case to reach is a status clear that lands in the same system cycle as a match step. From the pin, that step happens a fixed three clock edges after a rising edge on `slow_clk`. The bench first brings the prescaler to one edge short of a full second. It raises `slow_clk` just after a falling clock edge, counts two falling edges, and then places the clear write so that it is registered on the step edge. Random sequences of edges, match and mask writes, clears, restarts and start-value writes then exercise the rest against a bench model. Directed runs cover the wrap from all-ones and the discarded prescaler progress.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_FRESH = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2
    } rtc_state_e;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] RA_LOAD   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_MATCH  = 4'd1;
    localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd2;
    localparam logic [ADDR_W-1:0] RA_MASK   = 4'd3;
    localparam logic [ADDR_W-1:0] RA_RAW    = 4'd4;
    localparam logic [ADDR_W-1:0] RA_MASKED = 4'd5;
    localparam logic [ADDR_W-1:0] RA_CLEAR  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_COUNT  = 4'd7;
    localparam logic [ADDR_W-1:0] RA_VALUE  = 4'd8;

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // STAGES synchroniser flops followed by one history flop
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], async_in};
        end
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step_in,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = step_in & ~clear;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            logic [PW-1:0] phase;

            assign tick = step_in & ~clear & (phase == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase <= '0;
                end else if (clear) begin
                    phase <= '0;
                end else if (step_in) begin
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_count_fsm.sv
module rtc_count_fsm
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic [W-1:0] preload,
    output rtc_state_e   state,
    output logic [W-1:0] count,
    output logic         step,
    output logic         running
);
    rtc_state_e nxt_state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FRESH;
        end else begin
            state <= nxt_state;
        end
    end

    // transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_FRESH: if (enable)  nxt_state = ST_RUN;
            ST_RUN:   if (!enable) nxt_state = ST_HALT;
            ST_HALT:  if (enable)  nxt_state = ST_RUN;
            default:  nxt_state = ST_FRESH;
        endcase
    end

    // outputs
    assign running = (state == ST_RUN);
    assign step    = running & enable & tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state)
                ST_FRESH: if (enable) count <= W'(1);
                ST_RUN:   if (step)   count <= count + W'(1);
                ST_HALT:  if (enable) count <= preload;
                default:  count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rtc_second_counter.sv
module rtc_second_counter
    import rtc_pkg::*;
#(
    parameter int COUNT_W   = 32,
    parameter int DIV       = 32768,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [COUNT_W-1:0] wr_data,
    input  logic [3:0]        rd_addr,
    output logic [COUNT_W-1:0] rd_data,
    output logic              match_flag,
    output logic              irq
);
    logic               slow_rise;
    logic               sec_tick;
    logic               cnt_step;
    logic               running;
    rtc_state_e         cur_state;
    logic [COUNT_W-1:0] count_q;
    logic [COUNT_W-1:0] load_q;
    logic [COUNT_W-1:0] match_q;
    logic               en_q;
    logic               mask_q;
    logic               raw_q;
    logic               hit;
    logic               clr_req;

    rtc_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .rise     (slow_rise)
    );

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (~running),
        .step_in (slow_rise),
        .tick    (sec_tick)
    );

    rtc_count_fsm #(.W(COUNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_q),
        .tick    (sec_tick),
        .preload (load_q),
        .state   (cur_state),
        .count   (count_q),
        .step    (cnt_step),
        .running (running)
    );

    // writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '0;
            match_q <= '0;
            en_q    <= 1'b0;
            mask_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_LOAD:  load_q  <= wr_data;
                RA_MATCH: match_q <= wr_data;
                RA_CTRL:  en_q    <= wr_data[0];
                RA_MASK:  mask_q  <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // status: a match step wins over a clear in the same cycle
    assign hit     = cnt_step & ((count_q + COUNT_W'(1)) == match_q);
    assign clr_req = wr_en & (wr_addr == RA_CLEAR) & wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (hit) begin
            raw_q <= 1'b1;
        end else if (clr_req) begin
            raw_q <= 1'b0;
        end
    end

    assign match_flag = raw_q;
    assign irq        = raw_q & mask_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_LOAD:   rd_data = load_q;
            RA_MATCH:  rd_data = match_q;
            RA_CTRL:   rd_data[0] = en_q;
            RA_MASK:   rd_data[0] = mask_q;
            RA_RAW:    rd_data[0] = raw_q;
            RA_MASKED: rd_data[0] = raw_q & mask_q;
            RA_COUNT:  rd_data = count_q;
            RA_VALUE:  rd_data = count_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_second_counter_chk.sv
module rtc_second_counter_chk
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input rtc_state_e   state,
    input logic         en,
    input logic         step,
    input logic [W-1:0] count,
    input logic [W-1:0] match,
    input logic         raw,
    input logic         mask,
    input logic         irq,
    input logic         wr_en,
    input logic [3:0]   wr_addr,
    input logic         wr_bit0
);
    // R2
    fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRESH && en) |=> (count == W'(1)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) + W'(1)));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !en) |=> $stable(count));

    // R6
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ((count + W'(1)) == match)) |=> raw);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

    // R8
    irq_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);

    // R9
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CLEAR && wr_bit0 && !step) |=> !raw);
endmodule

bind rtc_second_counter rtc_second_counter_chk #(.W(COUNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (cur_state),
    .en      (en_q),
    .step    (cnt_step),
    .count   (count_q),
    .match   (match_q),
    .raw     (raw_q),
    .mask    (mask_q),
    .irq     (irq),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit0 (wr_data[0])
);

// File: tb/test_rtc_second_counter.sv
`timescale 1ns/1ps
module test_rtc_second_counter;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        match_flag;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] exp_count = '0, exp_load = '0, exp_match = '0;
    logic        exp_en = 1'b0, exp_mask = 1'b0, exp_raw = 1'b0, exp_fresh = 1'b1;
    int          exp_pre = 0;

    always #2.5 clk = ~clk;

    rtc_second_counter #(.COUNT_W(32), .DIV(PS), .SYNC_STGS(2)) i_rtc_second_counter (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .match_flag(match_flag), .irq(irq)
    );

    function automatic logic masked_of(logic r, logic m);
        return r & m;
    endfunction

    function automatic logic [31:0] bump(logic [31:0] c);
        return c + 32'd1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        logic [31:0] c;
        rd(4'd0, d); chk({tag, " R5 load"}, d, exp_load);
        rd(4'd1, d); chk({tag, " R6 match"}, d, exp_match);
        rd(4'd2, d); chk({tag, " R4 ctrl"}, d, {31'd0, exp_en});
        rd(4'd3, d); chk({tag, " R8 mask"}, d, {31'd0, exp_mask});
        rd(4'd4, d); chk({tag, " R6 raw"}, d, {31'd0, exp_raw});
        rd(4'd5, d); chk({tag, " R8 masked"}, d, {31'd0, masked_of(exp_raw, exp_mask)});
        chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, masked_of(exp_raw, exp_mask)});
        chk({tag, " R8 flag"}, {31'd0, match_flag}, {31'd0, exp_raw});
        rd(4'd7, c); chk({tag, " R3 count"}, c, exp_count);
        rd(4'd8, d); chk({tag, " R10 mirror"}, d, c);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        case (a)
            4'd0: exp_load = d;
            4'd1: exp_match = d;
            4'd2: begin
                if (d[0] && !exp_en) begin
                    exp_count = exp_fresh ? 32'd1 : exp_load;
                    exp_fresh = 1'b0;
                end
                exp_pre = 0;
                exp_en  = d[0];
            end
            4'd3: exp_mask = d[0];
            4'd6: if (d[0]) exp_raw = 1'b0;
            default: ;
        endcase
    endtask

    task automatic model_edge();
        if (exp_en) begin
            exp_pre++;
            if (exp_pre == PS) begin
                exp_pre   = 0;
                exp_count = bump(exp_count);
                if (exp_count == exp_match) exp_raw = 1'b1;
            end
        end
    endtask

    task automatic pulse();
        @(negedge clk); slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
        model_edge();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EC0_0D01));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_all("R1 reset");

        // R10 writes to read-only addresses do nothing
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);
        wr(4'd7, 32'h1234_5678);
        wr(4'd8, 32'h1234_5678);
        check_all("R10 ro-write");

        // R2 first start loads 1
        wr(4'd0, 32'd50);
        wr(4'd2, 32'd1);
        rd(4'd7, d); chk("R2 first start", d, 32'd1);

        // R3 partial and full prescale
        repeat (PS - 1) pulse();
        rd(4'd7, d); chk("R3 partial", d, 32'd1);
        pulse();
        rd(4'd7, d); chk("R3 full", d, 32'd2);

        // R4 stop holds
        wr(4'd2, 32'd0);
        repeat (PS + 1) pulse();
        rd(4'd7, d); chk("R4 halted", d, 32'd2);

        // R5 restart from load register
        wr(4'd2, 32'd1);
        rd(4'd7, d); chk("R5 reload", d, 32'd50);

        // R11 discarded prescaler progress
        repeat (PS - 1) pulse();
        wr(4'd2, 32'd0);
        wr(4'd0, 32'd70);
        wr(4'd2, 32'd1);
        repeat (PS - 1) pulse();
        rd(4'd7, d); chk("R11 restart", d, 32'd70);
        pulse();
        rd(4'd7, d); chk("R11 step", d, 32'd71);

        // R6 match and continue, R8 mask
        wr(4'd1, 32'd72);
        wr(4'd3, 32'd1);
        repeat (PS) pulse();
        check_all("R6 hit");
        repeat (PS) pulse();
        rd(4'd7, d); chk("R6 continues", d, 32'd73);
        wr(4'd3, 32'd0);
        check_all("R8 masked off");

        // R9 write 0 ignored, write 1 clears
        wr(4'd6, 32'd0);
        check_all("R9 zero write");
        wr(4'd6, 32'd1);
        check_all("R9 clear");

        // R9 set wins over same-cycle clear
        wr(4'd1, bump(exp_count));
        repeat (PS - 1) pulse();
        @(negedge clk); slow_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk); slow_clk = 1'b0;
        repeat (4) @(negedge clk);
        model_edge();
        exp_raw = 1'b1;
        check_all("R9 set wins");
        wr(4'd6, 32'd1);

        // R7 wrap from all ones
        wr(4'd2, 32'd0);
        wr(4'd0, 32'hFFFF_FFFE);
        wr(4'd1, 32'd0);
        wr(4'd2, 32'd1);
        repeat (PS) pulse();
        rd(4'd7, d); chk("R7 all ones", d, 32'hFFFF_FFFF);
        repeat (PS) pulse();
        check_all("R7 wrapped");
        repeat (PS) pulse();
        rd(4'd7, d); chk("R7 after wrap", d, 32'd1);

        // random mix
        for (int i = 0; i < 150; i++) begin
            int op;
            op = int'($urandom % 9);
            case (op)
                0, 1, 2, 3: pulse();
                4: wr(4'd1, exp_count + ($urandom % 3));
                5: wr(4'd3, {31'd0, 1'($urandom % 2)});
                6: wr(4'd6, {31'd0, 1'($urandom % 2)});
                7: wr(4'd2, {31'd0, ~exp_en});
                default: wr(4'd0, $urandom % 200);
            endcase
            check_all("RAND");
        end

        finish_run();
    end
endmodule